// File: doc/BRIEF.md
# Light Level Window Interrupt With Persistence

This block watches the stream of light readings produced at the end of each integration period. It decides whether the newest reading lies outside a window set by an upper and a lower threshold. Each threshold is one byte and is compared with the top byte of the 16-bit reading. A run of consecutive out-of-window readings is counted. When the run reaches the programmed persistence length (1, 4, 8 or 16 integration cycles), a sticky interrupt flag is raised. Short disturbances, such as a camera flash, are therefore filtered out.

The flag drives the enable of an external open-drain pull-down, so the shared interrupt line sits low while the flag is set. The register interface clears the flag with a one-cycle clear request when the host writes 0 to the flag bit.

Top module: `light_window_irq`

## Requirements
- R1: After reset, or whenever `rst_ni` is low, `flag_o` and `pull_en_o` are 0 and the consecutive-cycle count is zero. After reset, a full persistence run is needed before the flag can rise.
- R2: A reading is out of window when its top byte `reading_i[15:8]` is strictly greater than `thr_hi_i` or strictly less than `thr_lo_i`. A top byte equal to either threshold is in window. `reading_i[7:0]` has no effect.
- R3: Readings are evaluated only in cycles where `strobe_i` is 1. Cycles without a strobe neither advance nor reset the count, whatever `reading_i` holds.
- R4: `persist_i` selects the run length: 0 gives 1 reading, 1 gives 4, 2 gives 8 and 3 gives 16 consecutive out-of-window strobes. The flag becomes 1 in the cycle after the strobe that completes the run.
- R5: A strobe with an in-window reading returns the count to zero.
- R6: Once set, `flag_o` stays 1 until a clear request, even if later readings are in window.
- R7: A clear request (`flag_clr_i` = 1 for one cycle) sets `flag_o` to 0 in the next cycle. If the same cycle also completes a run, the flag is 1.
- R8: `pull_en_o` equals `flag_o` in every cycle. A 1 enables the pull-down, so the interrupt line is low.
- R9: The count saturates at the run length. After a clear, a single further out-of-window strobe, with no in-window strobe in between, sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | End-of-integration strobe; marks `reading_i` as new |
| reading_i | input | 16 | Latest light reading |
| thr_hi_i | input | 8 | Upper threshold byte (reset value held by the register interface: 0xFF) |
| thr_lo_i | input | 8 | Lower threshold byte (reset value held by the register interface: 0x00) |
| persist_i | input | 2 | Run length select: 0→1, 1→4, 2→8, 3→16 |
| flag_clr_i | input | 1 | One-cycle clear request from a host write of 0 to the flag bit |
| flag_o | output | 1 | Sticky interrupt flag: 1 = triggered, 0 = cleared or not yet triggered |
| pull_en_o | output | 1 | Enable of the open-drain pull-down; 1 drives the line low |

## Verification
A host clear request and a run-completing strobe can land in the same cycle. The flag logic must then resolve the conflict in favour of setting. The bench provokes this by placing three out-of-window strobes at 4-cycle persistence, then driving the fourth strobe together with `flag_clr_i`. It judges the outcome by sampling `flag_o` and `pull_en_o` one cycle later and expecting 1. It also checks the converse: a clear that comes with an in-window strobe ends with the flag at 0.

// File: rtl/lwi_pkg.sv
package lwi_pkg;

  typedef int unsigned u32_t;

  // run length for a persistence code: 0 -> 1, k>0 -> 2^(k+1)
  function automatic u32_t run_len(input u32_t sel);
    if (sel == 0) return 1;
    return u32_t'(1) << (sel + 1);
  endfunction

endpackage

// File: rtl/lwi_window_cmp.sv
module lwi_window_cmp #(
  parameter int READ_W = 16,
  parameter int THR_W  = 8
) (
  input  logic [READ_W-1:0] reading_i,
  input  logic [THR_W-1:0]  thr_hi_i,
  input  logic [THR_W-1:0]  thr_lo_i,
  output logic              above_o,
  output logic              below_o,
  output logic              outside_o
);

  localparam int LOW_W = READ_W - THR_W;

  logic [THR_W-1:0] top_byte;
  logic             unused_low;

  assign top_byte   = reading_i[READ_W-1 -: THR_W];
  assign unused_low = ^reading_i[LOW_W-1:0];

  assign above_o   = top_byte > thr_hi_i;
  assign below_o   = top_byte < thr_lo_i;
  assign outside_o = above_o | below_o;

endmodule

// File: rtl/lwi_persist_cnt.sv
module lwi_persist_cnt #(
  parameter int PERS_W = 2,
  parameter int CNT_W  = (1 << PERS_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              outside_i,
  input  logic [PERS_W-1:0] persist_i,
  output logic              fire_o
);

  import lwi_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_inc;

  assign target  = CNT_W'(run_len(u32_t'(persist_i)));
  // saturate at the selected run length
  assign cnt_inc = (cnt_q >= target) ? target : cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (strobe_i) cnt_d = outside_i ? cnt_inc : '0;
  end

  assign fire_o = strobe_i & outside_i & (cnt_inc >= target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lwi_flag.sv
module lwi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  // a set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (fire_i) flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/light_window_irq.sv
module light_window_irq #(
  parameter int READ_W = 16,
  parameter int THR_W  = 8,
  parameter int PERS_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [READ_W-1:0] reading_i,
  input  logic [THR_W-1:0]  thr_hi_i,
  input  logic [THR_W-1:0]  thr_lo_i,
  input  logic [PERS_W-1:0] persist_i,
  input  logic              flag_clr_i,
  output logic              flag_o,
  output logic              pull_en_o
);

  localparam int CNT_W = (1 << PERS_W) + 1;

  logic outside;
  logic unused_above, unused_below;
  logic fire;
  logic flag;

  lwi_window_cmp #(
    .READ_W (READ_W),
    .THR_W  (THR_W)
  ) u_cmp (
    .reading_i (reading_i),
    .thr_hi_i  (thr_hi_i),
    .thr_lo_i  (thr_lo_i),
    .above_o   (unused_above),
    .below_o   (unused_below),
    .outside_o (outside)
  );

  lwi_persist_cnt #(
    .PERS_W (PERS_W),
    .CNT_W  (CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe_i),
    .outside_i (outside),
    .persist_i (persist_i),
    .fire_o    (fire)
  );

  lwi_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .clr_i  (flag_clr_i),
    .flag_o (flag)
  );

  assign flag_o    = flag;
  assign pull_en_o = flag;

endmodule

// File: rtl/lwi_checks.sv
module lwi_checks #(
  parameter int READ_W = 16,
  parameter int THR_W  = 8,
  parameter int PERS_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic [READ_W-1:0] reading_i,
  input logic [THR_W-1:0]  thr_hi_i,
  input logic [THR_W-1:0]  thr_lo_i,
  input logic [PERS_W-1:0] persist_i,
  input logic              flag_clr_i,
  input logic              flag_o,
  input logic              pull_en_o
);

  logic [THR_W-1:0] hb;
  logic             out_win;

  assign hb      = reading_i[READ_W-1 -: THR_W];
  assign out_win = (hb > thr_hi_i) || (hb < thr_lo_i);

  always_comb begin
    if (!rst_ni) p_reset_quiet_r1: assert (!flag_o && !pull_en_o);
  end

  p_rise_needs_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(strobe_i));

  p_in_window_no_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !out_win && !flag_o |=> !flag_o);

  p_single_run_fires_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && out_win && persist_i == '0 |=> flag_o);

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o);

  p_clear_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !strobe_i |=> !flag_o);

  p_pull_tracks_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_en_o == flag_o);

endmodule

bind light_window_irq lwi_checks #(
  .READ_W (READ_W),
  .THR_W  (THR_W),
  .PERS_W (PERS_W)
) u_chk (.*);

// File: tb/light_window_irq_tb.sv
module light_window_irq_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [15:0] reading_i = '0;
  logic [7:0]  thr_hi_i = 8'hFF;
  logic [7:0]  thr_lo_i = 8'h00;
  logic [1:0]  persist_i = '0;
  logic        flag_clr_i = 1'b0;
  logic        flag_o, pull_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  light_window_irq u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe_i),
    .reading_i  (reading_i),
    .thr_hi_i   (thr_hi_i),
    .thr_lo_i   (thr_lo_i),
    .persist_i  (persist_i),
    .flag_clr_i (flag_clr_i),
    .flag_o     (flag_o),
    .pull_en_o  (pull_en_o)
  );

  // {strobe, clr, reading, hi, lo, persist, expected flag}
  localparam int NV = 29;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1,1'b0,16'h5000,8'h80,8'h20,2'd0,1'b0}, //  0 R2 in window
    {1'b1,1'b0,16'h8100,8'h80,8'h20,2'd0,1'b1}, //  1 R2/R4 above, run 1
    {1'b0,1'b1,16'h8100,8'h80,8'h20,2'd0,1'b0}, //  2 R7 clear
    {1'b1,1'b0,16'h80FF,8'h80,8'h20,2'd0,1'b0}, //  3 R2 equal hi, low byte ignored
    {1'b1,1'b0,16'h2000,8'h80,8'h20,2'd0,1'b0}, //  4 R2 equal lo
    {1'b1,1'b0,16'h1FFF,8'h80,8'h20,2'd0,1'b1}, //  5 R2 below
    {1'b0,1'b1,16'h1FFF,8'h80,8'h20,2'd0,1'b0}, //  6 R7 clear
    {1'b1,1'b0,16'h5000,8'h80,8'h20,2'd1,1'b0}, //  7 R5 reset count
    {1'b1,1'b0,16'h9000,8'h80,8'h20,2'd1,1'b0}, //  8 R4 1 of 4
    {1'b1,1'b0,16'h0100,8'h80,8'h20,2'd1,1'b0}, //  9 R4 2 of 4
    {1'b1,1'b0,16'hFF00,8'h80,8'h20,2'd1,1'b0}, // 10 R4 3 of 4
    {1'b1,1'b0,16'h5000,8'h80,8'h20,2'd1,1'b0}, // 11 R5 break run
    {1'b1,1'b0,16'h9000,8'h80,8'h20,2'd1,1'b0}, // 12 1 of 4
    {1'b0,1'b0,16'h5000,8'h80,8'h20,2'd1,1'b0}, // 13 R3 no strobe, in window
    {1'b1,1'b0,16'h9000,8'h80,8'h20,2'd1,1'b0}, // 14 2 of 4
    {1'b1,1'b0,16'h9000,8'h80,8'h20,2'd1,1'b0}, // 15 3 of 4
    {1'b1,1'b0,16'h9000,8'h80,8'h20,2'd1,1'b1}, // 16 R4 4 of 4
    {1'b1,1'b0,16'h5000,8'h80,8'h20,2'd1,1'b1}, // 17 R6 sticky
    {1'b0,1'b1,16'h5000,8'h80,8'h20,2'd1,1'b0}, // 18 R7 clear
    {1'b1,1'b0,16'hA000,8'h80,8'h20,2'd1,1'b0}, // 19 1 of 4
    {1'b1,1'b0,16'hA000,8'h80,8'h20,2'd1,1'b0}, // 20 2 of 4
    {1'b1,1'b0,16'hA000,8'h80,8'h20,2'd1,1'b0}, // 21 3 of 4
    {1'b1,1'b1,16'hA000,8'h80,8'h20,2'd1,1'b1}, // 22 R7 clear + fire -> set
    {1'b0,1'b1,16'hA000,8'h80,8'h20,2'd1,1'b0}, // 23 R7 clear
    {1'b1,1'b0,16'h9000,8'h80,8'h20,2'd1,1'b1}, // 24 R9 saturated refire
    {1'b1,1'b1,16'h5000,8'h80,8'h20,2'd1,1'b0}, // 25 R7 clear + in window
    {1'b1,1'b0,16'hFFFF,8'hFF,8'h00,2'd0,1'b0}, // 26 R2 default hi
    {1'b1,1'b0,16'h0000,8'hFF,8'h00,2'd0,1'b0}, // 27 R2 default lo
    {1'b1,1'b0,16'h00FF,8'hFF,8'h00,2'd0,1'b0}  // 28 R2
  };

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (flag_o !== exp || pull_en_o !== exp) begin
      n_bad++;
      $display("FAIL %s: flag_o=%b pull_en_o=%b expected %b", req, flag_o, pull_en_o, exp);
    end
  endtask

  // drive at negedge, evaluate at next negedge, strobe lasts one cycle
  task automatic step(input logic stb, input logic clr, input logic [15:0] rd,
                      input logic [7:0] hi, input logic [7:0] lo, input logic [1:0] ps,
                      input logic exp, input string req);
    strobe_i = stb; flag_clr_i = clr; reading_i = rd;
    thr_hi_i = hi; thr_lo_i = lo; persist_i = ps;
    @(negedge clk_i);
    check(req, exp);
    strobe_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset held", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      step(v[36], v[35], v[34:19], v[18:11], v[10:3], v[2:1], v[0],
           $sformatf("R2-table vec %0d", i));
    end

    // R4: run of 8
    step(1'b0, 1'b1, 16'h5000, 8'h80, 8'h20, 2'd2, 1'b0, "R7 pre-clear");
    step(1'b1, 1'b0, 16'h5000, 8'h80, 8'h20, 2'd2, 1'b0, "R5 zero count");
    for (int k = 1; k <= 8; k++)
      step(1'b1, 1'b0, 16'hC000, 8'h80, 8'h20, 2'd2, (k == 8),
           $sformatf("R4 run8 strobe %0d", k));

    // R1: reset in the middle of a 16 run restarts it
    step(1'b0, 1'b1, 16'h5000, 8'h80, 8'h20, 2'd3, 1'b0, "R7 clear before run16");
    step(1'b1, 1'b0, 16'h5000, 8'h80, 8'h20, 2'd3, 1'b0, "R5 zero count");
    for (int k = 1; k <= 10; k++)
      step(1'b1, 1'b0, 16'h0000, 8'h80, 8'h20, 2'd3, 1'b0,
           $sformatf("R4 run16 pre-reset %0d", k));
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 1; k <= 16; k++)
      step(1'b1, 1'b0, 16'h0000, 8'h80, 8'h20, 2'd3, (k == 16),
           $sformatf("R1 R4 run16 strobe %0d", k));

    // R8 / R6: idle cycles keep the flag and the pull-down
    repeat (3) @(negedge clk_i);
    check("R6 R8 idle hold", 1'b1);
    report();
  end

endmodule